// File: doc/BRIEF.md
# Chunked Packet Buffer with Free-List Manager

This block keeps variable-length packets in one data memory that is cut into equal chunks of `LINES` lines each. A FIFO of free chunk numbers supplies chunks to the writer. A link memory chains the chunks of each packet, and a per-chunk end flag marks the chunk that holds a packet's final line. Before starting a packet, the writer reads `first_chunk`, keeps it as the packet's handle, and then streams lines with `wr_en`. It marks the final line with `wr_last`.

A packet is read back by putting its handle on `sel_chunk` and pulsing `load_req`. After `req_ack`, each `rd_en` pulse returns one line on `rd_data` in the following cycle. When a chunk has been fully read, it goes back to the free list. The chunk that ends the packet is held until a `free_req` follows the read, and that request needs no handle. A packet that was never read is dropped by a `free_req` with its handle. The block then walks the chain and returns every chunk of the packet.

Top module: `chunk_pkt_buffer`

## Requirements
- R1: After an active-low asynchronous reset, `first_chunk` is 0, `free_none` and `req_ack` are 0, and `free_low` is 0 when `NCHUNK` > `AE_LVL`. Chunks are then handed out in ascending order 0, 1, 2, and so on.
- R2: A packet's first line goes into the chunk shown on `first_chunk` at that time. Afterwards `first_chunk` shows the next free chunk.
- R3: A packet of n lines occupies ceil(n/`LINES`) chunks, taken in free-list order. Reading it back returns the lines in the order they were written.
- R4: `free_low` is 1 exactly when the free count is at most `AE_LVL`. `free_none` is 1 exactly when the free count is zero.
- R5: A `wr_en` that needs a new chunk while `free_none` is 1 has no effect. It changes no stored data and no flag.
- R6: `req_ack` is 1 in the cycle after an accepted `load_req`. A `rd_en` sampled at an edge presents its line on `rd_data` after that edge.
- R7: During a read, each chunk whose last line has been read goes back to the tail of the free list. The chunk holding the packet's final line does not.
- R8: A `free_req` while a read is open returns the current chunk, whatever `sel_chunk` holds, and raises `req_ack` in the next cycle.
- R9: A `free_req` with no open read walks the chain from `sel_chunk`, returning one chunk per cycle in chain order. `req_ack` pulses in the cycle after the chunk with the end flag is returned, k cycles after acceptance for a k-chunk packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| wr_en | input | 1 | store one line |
| wr_data | input | LINE_W+EXTRA_W | line to store |
| wr_last | input | 1 | this line ends the packet |
| first_chunk | output | clog2(NCHUNK) | chunk the next packet will start at |
| free_low | output | 1 | free count at or below AE_LVL |
| free_none | output | 1 | no free chunk left |
| sel_chunk | input | clog2(NCHUNK) | packet handle for load or unread release |
| load_req | input | 1 | open a read at sel_chunk |
| free_req | input | 1 | release a packet |
| req_ack | output | 1 | load or release done |
| rd_en | input | 1 | fetch the next line of the open read |
| rd_data | output | LINE_W+EXTRA_W | fetched line |

## Verification
Damage to the free list appears at `first_chunk` at the next packet start. A lost or duplicated chunk shows up as a wrong allocation order, and a bad count shows up in `free_low` and `free_none` on the same edge. A broken link or end flag shows up either as wrong data on `rd_data` one cycle after the first `rd_en` past a chunk boundary, or as `req_ack` arriving in the wrong cycle during an unread release. Refilling an exhausted list lets the order in which chunks return be read back through `first_chunk`.

// File: rtl/chunk_pkt_buffer.sv
module chunk_pkt_buffer #(
  parameter int LINE_W  = 128,
  parameter int EXTRA_W = 2,
  parameter int NCHUNK  = 32,
  parameter int LINES   = 8,
  parameter int AE_LVL  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [LINE_W+EXTRA_W-1:0]     wr_data,
  input  logic                          wr_last,
  output logic [$clog2(NCHUNK)-1:0]     first_chunk,
  output logic                          free_low,
  output logic                          free_none,
  input  logic [$clog2(NCHUNK)-1:0]     sel_chunk,
  input  logic                          load_req,
  input  logic                          free_req,
  output logic                          req_ack,
  input  logic                          rd_en,
  output logic [LINE_W+EXTRA_W-1:0]     rd_data
);
  localparam int CW = $clog2(NCHUNK);
  localparam int OW = $clog2(LINES);
  localparam int DW = LINE_W + EXTRA_W;
  localparam logic [OW-1:0] OFF_END = OW'(LINES - 1);

  logic [DW-1:0] mem [NCHUNK*LINES];
  logic [CW-1:0] fl [NCHUNK];
  logic [CW-1:0] nxt [NCHUNK];
  logic [NCHUNK-1:0] end_flag;
  logic [CW-1:0] fl_head, fl_tail;
  logic [CW:0]   fl_cnt;

  logic          wr_open;
  logic [CW-1:0] wr_cur;
  logic [OW-1:0] wr_off;
  logic          rd_open;
  logic [CW-1:0] rd_cur;
  logic [OW-1:0] rd_off;
  logic          walking;
  logic [CW-1:0] walk_cur;

  assign free_none   = (fl_cnt == '0);
  assign free_low    = (fl_cnt <= (CW+1)'(AE_LVL));
  assign first_chunk = fl[fl_head];

  logic wr_new, wr_go, pop, load_go, rel_go, rd_go, rd_wrap, push, walk_end;
  logic [CW-1:0] wr_chunk, push_val;

  assign wr_new   = !wr_open || (wr_off == '0);
  assign wr_go    = wr_en && !(wr_new && free_none);
  assign pop      = wr_go && wr_new;
  assign wr_chunk = wr_new ? first_chunk : wr_cur;

  assign load_go  = load_req && !walking;
  assign rel_go   = free_req && !walking && !load_req;
  assign rd_go    = rd_en && rd_open && !walking && !load_req && !free_req;
  assign rd_wrap  = rd_go && (rd_off == OFF_END) && !end_flag[rd_cur];
  assign walk_end = walking && end_flag[walk_cur];
  assign push     = rd_wrap || (rel_go && rd_open) || walking;
  assign push_val = walking ? walk_cur : rd_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCHUNK; i++) fl[i] <= CW'(i);
      fl_head  <= '0;
      fl_tail  <= '0;
      fl_cnt   <= (CW+1)'(NCHUNK);
      end_flag <= '0;
      wr_open  <= 1'b0;
      wr_cur   <= '0;
      wr_off   <= '0;
      rd_open  <= 1'b0;
      rd_cur   <= '0;
      rd_off   <= '0;
      walking  <= 1'b0;
      walk_cur <= '0;
      req_ack  <= 1'b0;
    end else begin
      if (push) begin
        fl[fl_tail] <= push_val;
        fl_tail     <= fl_tail + 1'b1;
      end
      if (pop) fl_head <= fl_head + 1'b1;
      fl_cnt <= fl_cnt + (CW+1)'(push) - (CW+1)'(pop);

      if (wr_go) begin
        end_flag[wr_chunk] <= wr_last;
        wr_cur  <= wr_chunk;
        wr_open <= !wr_last;
        wr_off  <= wr_last ? '0 : wr_off + 1'b1;
      end

      req_ack <= load_go || (rel_go && rd_open) || walk_end;

      if (load_go) begin
        rd_open <= 1'b1;
        rd_cur  <= sel_chunk;
        rd_off  <= '0;
      end else if (rel_go) begin
        if (rd_open) rd_open <= 1'b0;
        else begin
          walking  <= 1'b1;
          walk_cur <= sel_chunk;
        end
      end else if (rd_go) begin
        rd_off <= rd_off + 1'b1;
        if (rd_wrap) rd_cur <= nxt[rd_cur];
      end

      if (walking) begin
        if (walk_end) walking <= 1'b0;
        else walk_cur <= nxt[walk_cur];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) mem[{wr_chunk, wr_off}] <= wr_data;
    if (pop && wr_open) nxt[wr_cur] <= first_chunk;
    if (rd_go) rd_data <= mem[{rd_cur, rd_off}];
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cnt <= (CW+1)'(NCHUNK)); // R4
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !free_none); // R5
  AST_EMPTY_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    free_none |-> free_low); // R4
  AST_LOAD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> req_ack && rd_open && rd_off == '0); // R6
  AST_WALK_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    walk_end |=> req_ack && !walking); // R9
  AST_REL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_go && rd_open) |=> req_ack && !rd_open); // R8
endmodule

// File: tb/sim_chunk_pkt_buffer.sv
module sim_chunk_pkt_buffer;
  localparam int LW = 14, EW = 2, NC = 8, LN = 4, AE = 2;
  localparam int DW = LW + EW, CW = $clog2(NC);

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_last = 0, load_req = 0, free_req = 0, rd_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic [CW-1:0] sel_chunk = '0;
  logic [CW-1:0] first_chunk;
  logic free_low, free_none, req_ack;
  logic [DW-1:0] rd_data;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  chunk_pkt_buffer #(.LINE_W(LW), .EXTRA_W(EW), .NCHUNK(NC), .LINES(LN), .AE_LVL(AE)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last),
    .first_chunk(first_chunk), .free_low(free_low), .free_none(free_none),
    .sel_chunk(sel_chunk), .load_req(load_req), .free_req(free_req),
    .req_ack(req_ack), .rd_en(rd_en), .rd_data(rd_data));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(int id, int ln);
    return {8'(id), 8'(ln)};
  endfunction

  task automatic wr_pkt(int id, int n, int exp_first);
    chk("R2 first_chunk", first_chunk, exp_first);
    for (int i = 0; i < n; i++) begin
      wr_en = 1; wr_data = pat(id, i); wr_last = (i == n - 1);
      @(negedge clk);
    end
    wr_en = 0; wr_last = 0;
  endtask

  task automatic load(int c);
    sel_chunk = CW'(c); load_req = 1;
    @(negedge clk);
    load_req = 0;
    chk("R6 ack after load", req_ack, 1);
  endtask

  task automatic rd_line(int id, int ln);
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    chk("R3 R6 rd_data", rd_data, pat(id, ln));
  endtask

  task automatic rel_after_read();
    sel_chunk = CW'(NC - 1); free_req = 1;
    @(negedge clk);
    free_req = 0;
    chk("R8 ack after release", req_ack, 1);
  endtask

  task automatic t_reset();
    chk("R1 first_chunk", first_chunk, 0);
    chk("R1 free_none", free_none, 0);
    chk("R1 free_low", free_low, 0);
    chk("R1 req_ack", req_ack, 0);
  endtask

  task automatic t_fill();
    wr_pkt(1, 1, 0);
    chk("R2 next chunk", first_chunk, 1);
    wr_pkt(2, 6, 1);
    chk("R3 two chunks used", first_chunk, 3);
    chk("R4 free_low at 5", free_low, 0);
    wr_pkt(3, 9, 3);
    chk("R3 three chunks used", first_chunk, 6);
    chk("R4 free_low at 2", free_low, 1);
    chk("R4 free_none at 2", free_none, 0);
    wr_pkt(4, 8, 6);
    chk("R4 free_none at 0", free_none, 1);
  endtask

  task automatic t_ignored();
    wr_en = 1; wr_data = 16'hBEEF; wr_last = 1;
    @(negedge clk);
    wr_en = 0; wr_last = 0;
    chk("R5 still empty", free_none, 1);
  endtask

  task automatic t_read_b();
    load(1);
    @(negedge clk);
    chk("R6 ack is a pulse", req_ack, 0);
    for (int i = 0; i < 4; i++) rd_line(2, i);
    chk("R7 chunk freed after read", free_none, 0);
    chk("R7 freed chunk at head", first_chunk, 1);
    rd_line(2, 4);
    rd_line(2, 5);
    chk("R7 last chunk held", free_low, 1);
    rel_after_read();
    chk("R8 count 2 still low", free_low, 1);
  endtask

  task automatic t_release_c();
    sel_chunk = 3; free_req = 1;
    @(negedge clk);
    free_req = 0;
    chk("R9 no ack at accept", req_ack, 0);
    @(negedge clk);
    chk("R9 no ack step1", req_ack, 0);
    @(negedge clk);
    chk("R9 no ack step2", req_ack, 0);
    @(negedge clk);
    chk("R9 ack after last chunk", req_ack, 1);
    chk("R4 free_low at 5", free_low, 0);
    @(negedge clk);
    chk("R9 ack is a pulse", req_ack, 0);
  endtask

  task automatic t_realloc();
    for (int k = 1; k <= 5; k++) wr_pkt(10 + k, 1, k);
    chk("R4 empty again", free_none, 1);
  endtask

  task automatic t_read_a_d();
    load(0);
    rd_line(1, 0);
    rel_after_read();
    chk("R8 one free", first_chunk, 0);
    load(6);
    for (int i = 0; i < 8; i++) rd_line(4, i);
    chk("R7 count 2 low", free_low, 1);
    rel_after_read();
    chk("R8 count 3 not low", free_low, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_ignored();
    t_read_b();
    t_release_c();
    t_realloc();
    t_read_a_d();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule